// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year covering 1970 to 2069. A prescaler divides the block clock (nominally 32768 Hz) down to one advance per second. The advance then passes through a carry chain: seconds into minutes, minutes into hours, hours into the day and weekday, the day into the month, and the month into the year. Month length comes from the month number and from a leap flag that software writes next to the year.

Software sets the time in two steps. It first writes each field into a staging copy, and these writes do not disturb the running time. It then writes the update register with its trigger bit set. In that one cycle every staged field moves into the live counter and the prescaler restarts. Reads always return the live time. A control bit picks between a 24-hour count and a 12-hour count that carries a PM flag.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the live time reads seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01, year 00 with the leap flag clear, and the control register reads 1 (24-hour mode).
- R2: Writes to addresses 0 to 6 (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year with the leap flag in bit 15) update only the staging copy. Reads of those addresses return the live time.
- R3: A write to address 7 with bit 15 set copies all seven staged fields, including the leap flag, into the live time in the same clock edge and restarts the prescaler. A write to address 7 with bit 15 clear has no effect. Address 7 reads as zero.
- R4: The live seconds advance exactly once every TICK_DIV clock cycles. The first advance falls TICK_DIV edges after reset or after a commit.
- R5: Seconds and minutes count 00 to 59 in BCD. Wrapping from 59 to 00 carries one into the next field.
- R6: In 24-hour mode (address 8 bit 0 = 1) hours count 00 to 23. Wrapping from 23 to 00 carries into the day.
- R7: In 12-hour mode (address 8 bit 0 = 0) the hour field holds BCD 01 to 12 in bits 4:0 and a PM flag in bit 5. 11 goes to 12 and toggles PM. 12 goes to 01 with PM unchanged. The day advances only when 11 PM becomes 12 AM.
- R8: The day counts from 01 up to the month's length, which is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. After the last day it returns to 01 and the month advances. Month 12 wraps to 01 and carries into the year.
- R9: February has 29 days when the leap flag is set and 28 days when it is clear.
- R10: The year counts 00 to 99 and wraps to 00. Every year advance clears the leap flag.
- R11: The weekday counts 0 to 6 and advances on every day rollover, wrapping from 6 to 0.
- R12: When a commit falls in the same cycle as a prescaler tick, the committed values win, the tick is discarded and the prescaler restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, nominally 32768 Hz |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Read data for rd_addr, combinational |

## Verification
The one cycle where two functions can collide is a commit written on the edge where the prescaler would also advance the seconds. The bench issues a commit, counts TICK_DIV-1 cycles, and then writes a second commit so that it lands exactly on the tick edge. It expects the staged seconds unchanged and the next advance a full TICK_DIV cycles later. A behavioural reference model of the prescaler and calendar is compared against one rotating field on every clock, which also catches any tick that leaks through.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic       leap;
        logic [7:0] year;
        logic [4:0] mon;
        logic [5:0] day;
        logic [2:0] wday;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_time_t;

    typedef struct packed {
        cal_time_t live;
        cal_time_t stage;
        logic      h24;
    } cal_regs_t;

    localparam cal_time_t CAL_RESET =
        {1'b0, 8'h00, 5'h01, 6'h01, 3'd0, 6'h00, 7'h00, 7'h00};

    localparam int ADR_SEC  = 0;
    localparam int ADR_MIN  = 1;
    localparam int ADR_HOUR = 2;
    localparam int ADR_WDAY = 3;
    localparam int ADR_DAY  = 4;
    localparam int ADR_MON  = 5;
    localparam int ADR_YEAR = 6;
    localparam int ADR_UPD  = 7;
    localparam int ADR_CTRL = 8;

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/cal_tick_gen.sv
module cal_tick_gen #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = cnt_q + CW'(1);
        if (clr || tick) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_chk
            // R4
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [4:0] mon,
    input  logic       leap,
    output logic [5:0] last_day
);
    always_comb begin
        case (mon)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/cal_carry_chain.sv
module cal_carry_chain
    import cal_pkg::*;
(
    input  cal_time_t cur,
    input  logic      h24,
    output cal_time_t nxt
);
    logic [5:0] last_day;
    logic       sec_wrap, min_wrap, day_wrap, mon_wrap, yr_wrap;

    cal_month_len u_mlen (
        .mon      (cur.mon),
        .leap     (cur.leap),
        .last_day (last_day)
    );

    always_comb begin
        nxt      = cur;
        min_wrap = 1'b0;
        day_wrap = 1'b0;
        mon_wrap = 1'b0;
        yr_wrap  = 1'b0;

        sec_wrap = (cur.sec == 7'h59);
        nxt.sec  = sec_wrap ? 7'h00 : 7'(bcd_inc8({1'b0, cur.sec}));

        if (sec_wrap) begin
            min_wrap = (cur.min == 7'h59);
            nxt.min  = min_wrap ? 7'h00 : 7'(bcd_inc8({1'b0, cur.min}));
        end

        if (sec_wrap && min_wrap) begin
            if (h24) begin
                day_wrap = (cur.hour == 6'h23);
                nxt.hour = day_wrap ? 6'h00 : 6'(bcd_inc8({2'b00, cur.hour}));
            end else if (cur.hour[4:0] == 5'h11) begin
                day_wrap = cur.hour[5];
                nxt.hour = {~cur.hour[5], 5'h12};
            end else if (cur.hour[4:0] == 5'h12) begin
                nxt.hour = {cur.hour[5], 5'h01};
            end else begin
                nxt.hour = {cur.hour[5], 5'(bcd_inc8({3'b000, cur.hour[4:0]}))};
            end
        end

        if (day_wrap) begin
            nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
            mon_wrap = (cur.day == last_day);
            nxt.day  = mon_wrap ? 6'h01 : 6'(bcd_inc8({2'b00, cur.day}));
        end

        if (mon_wrap) begin
            yr_wrap = (cur.mon == 5'h12);
            nxt.mon = yr_wrap ? 5'h01 : 5'(bcd_inc8({3'b000, cur.mon}));
        end

        if (yr_wrap) begin
            nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc8(cur.year);
            nxt.leap = 1'b0;
        end
    end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
    import cal_pkg::*;
#(
    parameter int TICK_DIV = 32768,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data
);
    cal_regs_t r_d, r_q;
    cal_time_t adv;
    logic      tick, commit;

    assign commit = wr_en && (wr_addr == ADDR_W'(ADR_UPD)) && wr_data[15];

    cal_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (commit),
        .tick  (tick)
    );

    cal_carry_chain u_chain (
        .cur (r_q.live),
        .h24 (r_q.h24),
        .nxt (adv)
    );

    always_comb begin
        r_d = r_q;
        if (commit)    r_d.live = r_q.stage;
        else if (tick) r_d.live = adv;
        if (wr_en) begin
            case (int'(wr_addr))
                ADR_SEC:  r_d.stage.sec  = wr_data[6:0];
                ADR_MIN:  r_d.stage.min  = wr_data[6:0];
                ADR_HOUR: r_d.stage.hour = wr_data[5:0];
                ADR_WDAY: r_d.stage.wday = wr_data[2:0];
                ADR_DAY:  r_d.stage.day  = wr_data[5:0];
                ADR_MON:  r_d.stage.mon  = wr_data[4:0];
                ADR_YEAR: begin
                    r_d.stage.year = wr_data[7:0];
                    r_d.stage.leap = wr_data[15];
                end
                ADR_CTRL: r_d.h24 = wr_data[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= {CAL_RESET, CAL_RESET, 1'b1};
        else        r_q <= r_d;
    end

    always_comb begin
        case (int'(rd_addr))
            ADR_SEC:  rd_data = {9'd0,  r_q.live.sec};
            ADR_MIN:  rd_data = {9'd0,  r_q.live.min};
            ADR_HOUR: rd_data = {10'd0, r_q.live.hour};
            ADR_WDAY: rd_data = {13'd0, r_q.live.wday};
            ADR_DAY:  rd_data = {10'd0, r_q.live.day};
            ADR_MON:  rd_data = {11'd0, r_q.live.mon};
            ADR_YEAR: rd_data = {r_q.live.leap, 7'd0, r_q.live.year};
            ADR_CTRL: rd_data = {15'd0, r_q.h24};
            default:  rd_data = 16'h0000;
        endcase
    end

    // R3
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (r_q.live == $past(r_q.stage)));
    // R12
    commit_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && tick) |=> (r_q.live.sec == $past(r_q.stage.sec)));
    // R2
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !tick) |=> $stable(r_q.live));
    // R5
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !commit && r_q.live.sec == 7'h59) |=> (r_q.live.sec == 7'h00));
    // R10
    leap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit) && r_q.live.year != $past(r_q.live.year)) |-> !r_q.live.leap);
endmodule

// File: tb/bcd_calendar_counter_tb.sv
module bcd_calendar_counter_tb_top;
    localparam int CLK_P  = 10;
    localparam int TB_DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr;
    logic [15:0] rd_data;
    logic        dir_rd = 1'b0;
    logic [3:0]  dir_addr = '0;
    logic [3:0]  rot_addr = '0;
    logic        cmp_en = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state (binary)
    int m_sec, m_min, m_hr24, m_wday, m_day, m_mon, m_year, m_leap, m_h24, m_pc;
    int stg [7];

    always #(CLK_P/2) clk = ~clk;
    assign rd_addr = dir_rd ? dir_addr : rot_addr;

    bcd_calendar_counter #(.TICK_DIV(TB_DIV), .ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int b2bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction
    function automatic int bcd2b(input int v);
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction
    function automatic int days_in(input int mon, input int leap);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction
    function automatic int hour_enc(input int h, input int h24);
        int h12;
        if (h24 != 0) return b2bcd(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return ((h >= 12) ? 32 : 0) | b2bcd(h12);
    endfunction
    function automatic int model_field(input int a);
        case (a)
            0: return b2bcd(m_sec);
            1: return b2bcd(m_min);
            2: return hour_enc(m_hr24, m_h24);
            3: return m_wday;
            4: return b2bcd(m_day);
            5: return b2bcd(m_mon);
            default: return (m_leap << 15) | b2bcd(m_year);
        endcase
    endfunction
    function automatic string field_tag(input int a);
        case (a)
            0, 1: return "R5";
            2: return (m_h24 != 0) ? "R6" : "R7";
            3: return "R11";
            4, 5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr24 = 0; m_wday = 0; m_day = 1; m_mon = 1;
        m_year = 0; m_leap = 0; m_h24 = 1; m_pc = 0;
        stg[0] = 0; stg[1] = 0; stg[2] = 0; stg[3] = 0; stg[4] = 1; stg[5] = 1; stg[6] = 0;
    endtask

    task automatic model_advance();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr24++;
                if (m_hr24 == 24) begin
                    m_hr24 = 0;
                    m_wday = (m_wday + 1) % 7;
                    m_day++;
                    if (m_day > days_in(m_mon, m_leap)) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_year = (m_year + 1) % 100;
                            m_leap = 0;
                        end
                    end
                end
            end
        end
    endtask

    task automatic model_commit();
        int h12;
        m_sec  = bcd2b(stg[0]);
        m_min  = bcd2b(stg[1]);
        if (m_h24 != 0) m_hr24 = bcd2b(stg[2]);
        else begin
            h12 = bcd2b(stg[2] & 8'h1f);
            m_hr24 = (h12 % 12) + (((stg[2] >> 5) & 1) != 0 ? 12 : 0);
        end
        m_wday = stg[3];
        m_day  = bcd2b(stg[4]);
        m_mon  = bcd2b(stg[5]);
        m_year = bcd2b(stg[6] & 8'hff);
        m_leap = (stg[6] >> 15) & 1;
        m_pc   = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            if (wr_en && wr_addr == 4'd7 && wr_data[15]) model_commit();
            else if (m_pc == TB_DIV - 1) begin m_pc = 0; model_advance(); end
            else m_pc++;
            if (wr_en) begin
                case (wr_addr)
                    4'd0, 4'd1: stg[wr_addr] = int'(wr_data & 16'h007f);
                    4'd2, 4'd4: stg[wr_addr] = int'(wr_data & 16'h003f);
                    4'd3: stg[3] = int'(wr_data & 16'h0007);
                    4'd5: stg[5] = int'(wr_data & 16'h001f);
                    4'd6: stg[6] = int'(wr_data & 16'h80ff);
                    4'd8: m_h24 = int'(wr_data[0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // model comparison on every clock, one rotating field per cycle
    always @(posedge clk) begin
        #(CLK_P/4);
        if (cmp_en && !dir_rd) chk(field_tag(int'(rot_addr)), int'(rd_data), model_field(int'(rot_addr)));
        rot_addr <= (rot_addr == 4'd6) ? 4'd0 : rot_addr + 4'd1;
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask
    task automatic rd(input int a, output int v);
        dir_rd = 1'b1; dir_addr = 4'(a);
        #1 v = int'(rd_data);
        dir_rd = 1'b0;
    endtask
    task automatic stage_time(input int s, input int mi, input int h, input int wd,
                              input int dy, input int mo, input int yr);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, wd); wr(4, dy); wr(5, mo); wr(6, yr);
    endtask
    task automatic load_time(input int s, input int mi, input int h, input int wd,
                             input int dy, input int mo, input int yr);
        stage_time(s, mi, h, wd, dy, mo, yr);
        wr(7, 16'h8000);
    endtask
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1 reset state
        rd(0, v); chk("R1", v, 0);
        rd(2, v); chk("R1", v, 0);
        rd(4, v); chk("R1", v, 16'h01);
        rd(5, v); chk("R1", v, 16'h01);
        rd(6, v); chk("R1", v, 0);
        rd(8, v); chk("R1", v, 1);

        // R4 tick spacing after commit
        load_time(16'h00, 16'h00, 16'h00, 0, 16'h01, 16'h01, 16'h00);
        for (int j = 1; j <= TB_DIV; j++) begin
            wait_cyc(1); rd(0, v); chk("R4", v, (j == TB_DIV) ? 1 : 0);
        end

        // R2 staging does not touch live
        load_time(16'h30, 16'h20, 16'h10, 2, 16'h05, 16'h06, 16'h24);
        wr(0, 16'h45);
        rd(0, v); chk("R2", v, 16'h30);
        rd(1, v); chk("R2", v, 16'h20);

        // R3 trigger bit clear ignored, set commits
        stage_time(16'h12, 16'h34, 16'h05, 3, 16'h07, 16'h08, 16'h8033);
        wr(7, 16'h7fff);
        rd(1, v); chk("R3", v, 16'h20);
        rd(7, v); chk("R3", v, 0);
        wr(7, 16'h8000);
        rd(1, v); chk("R3", v, 16'h34);
        rd(6, v); chk("R3", v, 16'h8033);

        // R5 R6 R11 full day rollover
        load_time(16'h59, 16'h59, 16'h23, 6, 16'h15, 16'h03, 16'h10);
        wait_cyc(TB_DIV);
        rd(0, v); chk("R5", v, 0);
        rd(1, v); chk("R5", v, 0);
        rd(2, v); chk("R6", v, 0);
        rd(3, v); chk("R11", v, 0);
        rd(4, v); chk("R8", v, 16'h16);

        // R8 month lengths
        load_time(16'h59, 16'h59, 16'h23, 1, 16'h30, 16'h04, 16'h10);
        wait_cyc(TB_DIV);
        rd(4, v); chk("R8", v, 16'h01); rd(5, v); chk("R8", v, 16'h05);
        load_time(16'h59, 16'h59, 16'h23, 1, 16'h30, 16'h05, 16'h10);
        wait_cyc(TB_DIV);
        rd(4, v); chk("R8", v, 16'h31); rd(5, v); chk("R8", v, 16'h05);
        load_time(16'h59, 16'h59, 16'h23, 1, 16'h30, 16'h11, 16'h10);
        wait_cyc(TB_DIV);
        rd(5, v); chk("R8", v, 16'h12);

        // R9 February with and without leap flag
        load_time(16'h59, 16'h59, 16'h23, 1, 16'h28, 16'h02, 16'h23);
        wait_cyc(TB_DIV);
        rd(4, v); chk("R9", v, 16'h01); rd(5, v); chk("R9", v, 16'h03);
        load_time(16'h59, 16'h59, 16'h23, 1, 16'h28, 16'h02, 16'h8024);
        wait_cyc(TB_DIV);
        rd(4, v); chk("R9", v, 16'h29); rd(5, v); chk("R9", v, 16'h02);
        load_time(16'h59, 16'h59, 16'h23, 1, 16'h29, 16'h02, 16'h8024);
        wait_cyc(TB_DIV);
        rd(4, v); chk("R9", v, 16'h01); rd(5, v); chk("R9", v, 16'h03);

        // R10 year wrap and leap clear
        load_time(16'h59, 16'h59, 16'h23, 4, 16'h31, 16'h12, 16'h8099);
        wait_cyc(TB_DIV);
        rd(6, v); chk("R10", v, 16'h0000); rd(5, v); chk("R10", v, 16'h01);
        load_time(16'h59, 16'h59, 16'h23, 4, 16'h31, 16'h12, 16'h8023);
        wait_cyc(TB_DIV);
        rd(6, v); chk("R10", v, 16'h0024);

        // R7 12-hour mode
        cmp_en = 1'b0;
        wr(8, 0);
        load_time(16'h59, 16'h59, 16'h31, 2, 16'h10, 16'h06, 16'h30);
        cmp_en = 1'b1;
        wait_cyc(TB_DIV);
        rd(2, v); chk("R7", v, 16'h12); rd(4, v); chk("R7", v, 16'h11);
        load_time(16'h59, 16'h59, 16'h11, 2, 16'h10, 16'h06, 16'h30);
        wait_cyc(TB_DIV);
        rd(2, v); chk("R7", v, 16'h32); rd(4, v); chk("R7", v, 16'h10);
        load_time(16'h59, 16'h59, 16'h32, 2, 16'h10, 16'h06, 16'h30);
        wait_cyc(TB_DIV);
        rd(2, v); chk("R7", v, 16'h21);
        cmp_en = 1'b0;
        wr(8, 1);
        load_time(16'h00, 16'h00, 16'h08, 0, 16'h01, 16'h01, 16'h00);
        cmp_en = 1'b1;

        // R12 commit on the tick edge
        load_time(16'h05, 16'h00, 16'h08, 0, 16'h01, 16'h01, 16'h00);
        wr(0, 16'h10);
        wait_cyc(TB_DIV - 2);
        wr(7, 16'h8000);
        rd(0, v); chk("R12", v, 16'h10);
        wait_cyc(TB_DIV - 1);
        rd(0, v); chk("R12", v, 16'h10);
        wait_cyc(1);
        rd(0, v); chk("R12", v, 16'h11);

        wait_cyc(20);
        summary();
        $finish;
    end
endmodule